// File: doc/BRIEF.md
# Mode-Selected Extraction Permit Combiner

This block decides whether beam may be extracted towards a transfer line and a downstream ring. It combines ten condition inputs into one permit. None of the inputs can be masked. The inputs are:

- a software interlock
- a source-side permit
- two dump-block position reports
- the permits of the upstream and downstream line sections
- a ring injection permit
- three beam-condition flags: probe, beam present and setup

The permit is not a plain AND of the inputs. It is a sum of products. A dump block reported as inserted stops the beam, so every permit located after that block drops out of the product.

A 3-bit mode code selects one of five operating modes. The modes are:

- beam to the upstream dump
- beam onto the downstream dump
- probe beam into the ring
- low-intensity fill
- high-intensity beam

The combinational result is registered, so the output is a clean, glitch-free permit one clock after the inputs settle. Reset holds the permit FALSE until the first evaluation after reset has been registered.

Top module: `mpl_master_permit`

## Requirements

In the requirements below, "path" means `src_ok AND (blk_up_in OR (line_up_ok AND (blk_dn_in OR (line_dn_ok AND ring_inj_ok)))).`

- R1: While `rst_n` is low, `permit_o` is 0. After `rst_n` is released, `permit_o` stays 0 until the first rising clock edge with `rst_n` high has registered an evaluation.
- R2: `permit_o` changes only at a rising clock edge. Its value is the permit function of the inputs present just before that edge.
- R3: Any `mode_sel` value outside 1 to 5 (that is 0, 6 or 7) gives `permit_o` = 0.
- R4: `sw_ok` = 0 gives `permit_o` = 0 in every mode.
- R5: Mode 1 (upstream dump): permit = `sw_ok AND src_ok AND blk_up_in`.
- R6: Mode 2 (downstream dump): permit = `sw_ok AND src_ok AND (blk_up_in OR (line_up_ok AND blk_dn_in))`.
- R7: In modes 2 to 5, with `blk_up_in` = 1, the inputs `line_up_ok`, `blk_dn_in`, `line_dn_ok` and `ring_inj_ok` have no effect on `permit_o`.
- R8: In modes 3 to 5, with `blk_up_in` = 0 and `blk_dn_in` = 1, the inputs `line_dn_ok` and `ring_inj_ok` have no effect on `permit_o`.
- R9: Mode 3 (probe): permit = `sw_ok AND path AND flag_probe`.
- R10: Mode 4 (low-intensity fill): permit = `sw_ok AND path AND flag_setup`.
- R11: Mode 5 (high intensity): permit = `sw_ok AND path AND flag_present AND NOT flag_probe AND NOT flag_setup`. When both blocks are out, this requires `src_ok`, `line_up_ok`, `line_dn_ok` and `ring_inj_ok` all to be 1.
- R12: `src_ok` = 0 gives `permit_o` = 0 in every mode; no input is maskable.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Operating mode code, 1 to 5 valid |
| sw_ok | input | 1 | Software interlock, 1 = OK |
| src_ok | input | 1 | Source-side permit, 1 = OK |
| blk_up_in | input | 1 | Upstream dump block inserted |
| line_up_ok | input | 1 | Upstream line section permit |
| line_dn_ok | input | 1 | Downstream line section permit |
| blk_dn_in | input | 1 | Downstream dump block inserted |
| ring_inj_ok | input | 1 | Ring injection permit |
| flag_probe | input | 1 | Probe-beam flag |
| flag_present | input | 1 | Beam-present-in-ring flag |
| flag_setup | input | 1 | Setup-beam flag |
| permit_o | output | 1 | Registered extraction permit |

## Verification

The bench builds the block with its default parameters: a 3-bit mode field and five modes. With these values the whole input space is only 8192 patterns (eight mode codes times 1024 condition combinations). The bench walks all of them, one per clock, against a reference model that reasons about how far the beam travels before a block stops it. This exercises every invalid code, every block-bypass case and every flag combination. Directed steps before the sweep cover the reset hold, the first registered evaluation and the one-edge latency.

// File: rtl/mpl_pkg.sv
// Package: shared types and constants of the extraction permit combiner.
// Assumes mode codes 1..NUM_MODES are valid and code 0 means "off".
package mpl_pkg;

    localparam int MODE_W    = 3;
    localparam int NUM_MODES = 5;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF     = 3'd0,
        MODE_UP_DUMP = 3'd1,
        MODE_DN_DUMP = 3'd2,
        MODE_PROBE   = 3'd3,
        MODE_LOW     = 3'd4,
        MODE_HIGH    = 3'd5
    } mode_e;

    // Condition bundle, all bits active-high "OK" / "inserted" / "flag set".
    typedef struct packed {
        logic sw;
        logic src;
        logic blk_up;
        logic line_up;
        logic line_dn;
        logic blk_dn;
        logic inj;
        logic probe;
        logic present;
        logic setup;
    } cond_t;

endpackage

// File: rtl/mpl_path_eval.sv
// Module: evaluates the beam-path products of the OR-of-AND permit.
// Each output is one product: the permits needed for the beam to stop
// at the upstream block, at the downstream block, or reach the ring.
// Assumes the condition bits are already synchronous to the caller's clock.
module mpl_path_eval
    import mpl_pkg::*;
(
    input  cond_t cond,
    output logic  stop_up,
    output logic  stop_dn,
    output logic  reach_ring,
    output logic  path_ok
);

    // Compute each product and their sum; later permits are absent from
    // the products that end at an inserted block.
    always_comb begin
        stop_up    = cond.src & cond.blk_up;
        stop_dn    = cond.src & cond.line_up & cond.blk_dn;
        reach_ring = cond.src & cond.line_up & cond.line_dn & cond.inj;
        path_ok    = stop_up | stop_dn | reach_ring;
    end

endmodule

// File: rtl/mpl_mode_terms.sv
// Module: builds one candidate permit term per operating mode.
// Term index m-1 belongs to mode code m. The software interlock is not
// applied here; the selector applies it to every mode.
module mpl_mode_terms
    import mpl_pkg::*;
#(
    parameter int N_MODES = NUM_MODES
) (
    input  cond_t              cond,
    input  logic               stop_up,
    input  logic               stop_dn,
    input  logic               path_ok,
    output logic [N_MODES-1:0] term
);

    genvar m;
    generate
        for (m = 0; m < N_MODES; m++) begin : g_term
            if (m + 1 == int'(MODE_UP_DUMP)) begin : g_up
                // Beam ends at the upstream block only.
                always_comb term[m] = stop_up;
            end else if (m + 1 == int'(MODE_DN_DUMP)) begin : g_dn
                // Beam ends at either block, never in the ring.
                always_comb term[m] = stop_up | stop_dn;
            end else if (m + 1 == int'(MODE_PROBE)) begin : g_probe
                // Any valid path with the probe flag set.
                always_comb term[m] = path_ok & cond.probe;
            end else if (m + 1 == int'(MODE_LOW)) begin : g_low
                // Any valid path with the setup-beam flag set.
                always_comb term[m] = path_ok & cond.setup;
            end else if (m + 1 == int'(MODE_HIGH)) begin : g_high
                // Full-intensity: beam present, no probe or setup flag.
                always_comb term[m] = path_ok & cond.present
                                      & ~cond.probe & ~cond.setup;
            end else begin : g_none
                // Modes beyond the defined set never grant.
                always_comb term[m] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/mpl_mode_select.sv
// Module: decodes the mode code one-hot and picks the matching term.
// Codes outside 1..N_MODES decode to no hit, so the permit is FALSE.
module mpl_mode_select #(
    parameter int MW      = 3,
    parameter int N_MODES = 5
) (
    input  logic [MW-1:0]      mode_sel,
    input  logic               sw_ok,
    input  logic [N_MODES-1:0] term,
    output logic               permit_next
);

    logic [N_MODES-1:0] hit;

    genvar m;
    generate
        for (m = 0; m < N_MODES; m++) begin : g_dec
            // One-hot decode of mode code m+1.
            always_comb hit[m] = (mode_sel == MW'(m + 1));
        end
    endgenerate

    // AND-OR select gated by the software interlock.
    always_comb permit_next = sw_ok & (|(hit & term));

endmodule

// File: rtl/mpl_master_permit.sv
// Module: top of the mode-selected extraction permit combiner.
// Bundles the ten unmaskable conditions, evaluates the sum of products for
// the selected mode and registers the result. Synchronous active-low reset
// holds the permit FALSE until the first evaluation after release.
module mpl_master_permit
    import mpl_pkg::*;
#(
    parameter int MW      = MODE_W,
    parameter int N_MODES = NUM_MODES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode_sel,
    input  logic          sw_ok,
    input  logic          src_ok,
    input  logic          blk_up_in,
    input  logic          line_up_ok,
    input  logic          line_dn_ok,
    input  logic          blk_dn_in,
    input  logic          ring_inj_ok,
    input  logic          flag_probe,
    input  logic          flag_present,
    input  logic          flag_setup,
    output logic          permit_o
);

    cond_t              cond;
    logic               stop_up;
    logic               stop_dn;
    logic               reach_ring;
    logic               path_ok;
    logic [N_MODES-1:0] term;
    logic               permit_next;
    logic               permit_q;

    // Gather the input pins into the shared condition bundle.
    always_comb begin
        cond.sw      = sw_ok;
        cond.src     = src_ok;
        cond.blk_up  = blk_up_in;
        cond.line_up = line_up_ok;
        cond.line_dn = line_dn_ok;
        cond.blk_dn  = blk_dn_in;
        cond.inj     = ring_inj_ok;
        cond.probe   = flag_probe;
        cond.present = flag_present;
        cond.setup   = flag_setup;
    end

    mpl_path_eval u_path (
        .cond       (cond),
        .stop_up    (stop_up),
        .stop_dn    (stop_dn),
        .reach_ring (reach_ring),
        .path_ok    (path_ok)
    );

    mpl_mode_terms #(.N_MODES(N_MODES)) u_terms (
        .cond    (cond),
        .stop_up (stop_up),
        .stop_dn (stop_dn),
        .path_ok (path_ok),
        .term    (term)
    );

    mpl_mode_select #(.MW(MW), .N_MODES(N_MODES)) u_sel (
        .mode_sel    (mode_sel),
        .sw_ok       (cond.sw),
        .term        (term),
        .permit_next (permit_next)
    );

    // Register the permit; reset forces it FALSE.
    always_ff @(posedge clk) begin
        if (!rst_n) permit_q <= 1'b0;
        else        permit_q <= permit_next;
    end

    assign permit_o = permit_q;

endmodule

// File: rtl/mpl_master_permit_chk.sv
// Module: property checker for the permit combiner, bound to the top.
// Assumes the 3-bit mode field of the default build.
module mpl_master_permit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_sel,
    input logic       sw_ok,
    input logic       src_ok,
    input logic       blk_up_in,
    input logic       flag_probe,
    input logic       flag_setup,
    input logic       permit_o
);

    // R1: first cycle after release still shows the reset value.
    a_r1_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !permit_o);

    // R3: invalid mode codes never grant.
    a_r3_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd0 || mode_sel > 3'd5) |=> !permit_o);

    // R4: software interlock vetoes every mode.
    a_r4_sw_veto: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_ok |=> !permit_o);

    // R5: upstream-dump mode needs the upstream block inserted.
    a_r5_up_block: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd1 && !blk_up_in) |=> !permit_o);

    // R11: high intensity refused with probe or setup flag.
    a_r11_high_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd5 && (flag_probe || flag_setup)) |=> !permit_o);

    // R12: source permit cannot be masked.
    a_r12_src_veto: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ok |=> !permit_o);

endmodule

bind mpl_master_permit mpl_master_permit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .sw_ok      (sw_ok),
    .src_ok     (src_ok),
    .blk_up_in  (blk_up_in),
    .flag_probe (flag_probe),
    .flag_setup (flag_setup),
    .permit_o   (permit_o)
);

// File: tb/mpl_master_permit_bench.sv
// Bench: directed reset/latency steps, then an exhaustive sweep of all
// mode codes and condition patterns against a behavioural model.
module mpl_master_permit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       sw_ok = 1'b0, src_ok = 1'b0, blk_up_in = 1'b0;
    logic       line_up_ok = 1'b0, line_dn_ok = 1'b0, blk_dn_in = 1'b0;
    logic       ring_inj_ok = 1'b0, flag_probe = 1'b0;
    logic       flag_present = 1'b0, flag_setup = 1'b0;
    logic       permit_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    mpl_master_permit u_mpl_master_permit (
        .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel),
        .sw_ok (sw_ok), .src_ok (src_ok), .blk_up_in (blk_up_in),
        .line_up_ok (line_up_ok), .line_dn_ok (line_dn_ok),
        .blk_dn_in (blk_dn_in), .ring_inj_ok (ring_inj_ok),
        .flag_probe (flag_probe), .flag_present (flag_present),
        .flag_setup (flag_setup), .permit_o (permit_o)
    );

    // Model: how far does beam travel, and which permits does that need.
    function automatic bit model(int mode, bit sw, bit src, bit bu, bit lu,
                                 bit ld, bit bd, bit inj, bit pr, bit pres,
                                 bit su);
        int  reach;
        bit  lines;
        if (mode < 1 || mode > 5) return 1'b0;
        if (!sw) return 1'b0;
        reach = bu ? 1 : (bd ? 2 : 3);
        lines = src && (reach < 2 || lu) && (reach < 3 || (ld && inj));
        case (mode)
            1: return src && reach == 1;
            2: return lines && reach <= 2;
            3: return lines && pr;
            4: return lines && su;
            default: return lines && pres && !pr && !su;
        endcase
    endfunction

    // Requirement that governs a given pattern, for the report.
    function automatic string tag_of(int mode, bit sw, bit src, bit bu, bit bd);
        if (mode < 1 || mode > 5) return "R3";
        if (!sw) return "R4";
        if (!src) return "R12";
        if (mode == 1) return "R5";
        if (mode == 2) return "R6";
        if (bu) return "R7";
        if (bd) return "R8";
        if (mode == 3) return "R9";
        if (mode == 4) return "R10";
        return "R11";
    endfunction

    task automatic check(string req, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: permit_o=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic drive(int mode, logic [9:0] v);
        mode_sel     = 3'(mode);
        sw_ok        = v[0];
        src_ok       = v[1];
        blk_up_in    = v[2];
        line_up_ok   = v[3];
        line_dn_ok   = v[4];
        blk_dn_in    = v[5];
        ring_inj_ok  = v[6];
        flag_probe   = v[7];
        flag_present = v[8];
        flag_setup   = v[9];
    endtask

    // sw, src, line_up, line_dn, inj, present set; blocks out, probe/setup clear
    localparam logic [9:0] HIGH_OK = 10'b01_0101_1011;

    initial begin
        // R1: held in reset with a granting pattern applied.
        drive(5, HIGH_OK);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", permit_o, 1'b0);
        end
        rst_n = 1'b1;
        #1 check("R1", permit_o, 1'b0);
        @(negedge clk);
        check("R1", permit_o, 1'b1);
        // R2: a new input is not visible before the next edge.
        drive(5, HIGH_OK & ~10'b1);
        #1 check("R2", permit_o, 1'b1);
        @(negedge clk);
        check("R2", permit_o, 1'b0);
        // R7: upstream block in, all later permits withdrawn, mode 5.
        drive(5, 10'b01_0000_0111);
        @(negedge clk);
        check("R7", permit_o, 1'b1);
        // R8: downstream block in, downstream permits withdrawn, mode 3.
        drive(3, 10'b00_1010_1011);
        @(negedge clk);
        check("R8", permit_o, 1'b1);
        // Exhaustive sweep, one pattern per clock.
        for (int k = 0; k < 8192; k++) begin
            logic [9:0] v;
            int         md;
            v  = k[9:0];
            md = k >> 10;
            drive(md, v);
            @(negedge clk);
            check(tag_of(md, v[0], v[1], v[2], v[5]), permit_o,
                  model(md, v[0], v[1], v[2], v[3], v[4], v[5], v[6],
                        v[7], v[8], v[9]));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule